// File: doc/BRIEF.md
# Lazy overflow flag evaluator

This block keeps a record of the most recent flag-setting operation and derives the overflow flag from it only when the flag is read. The record holds an operation kind, three operand values (source, destination and result) and a width selector for byte or word. The overflow flag itself is never stored.

A processor core pulses the load strobe together with a new record whenever an instruction sets the flags. From the next cycle on, the overflow output gives the flag for that record. Each operation kind uses its own rule: increment, decrement, subtract and shift work on the saved values, and the eager kind takes the flag straight from a precomputed flag word held in the result field.

Top module: `ovf_lazy_top`

## Requirements
- R1: After reset the stored kind is eager and the result is zero, so `ofOut` is 0.
- R2: When `loadEn` is high at a rising clock edge, the kind, source, destination, result and width are captured together. `ofOut` shows the new record from the cycle after that edge. Until that edge it keeps the old value. With `loadEn` low, `ofOut` does not change.
- R3: Increment (kind code 1) sets OF exactly when the result equals the sign-bit mask: 0x80 for byte width, 0x8000 for word width.
- R4: Decrement (kind code 2) sets OF exactly when the result equals the sign-bit mask minus one: 0x7F for byte width, 0x7FFF for word width.
- R5: Subtract (kind code 3) sets OF when the source and destination sign bits differ and the result sign bit differs from the destination sign bit.
- R6: Shift (kind code 4) sets OF to the sign bit of destination XOR result.
- R7: Eager (kind code 0) sets OF to bit 11 of the stored result, whatever the width.
- R8: Byte width (`loadWide` = 0) uses bit 7 as the sign bit and ignores bits 15:8 of source, destination and result for the increment, decrement, subtract and shift kinds. Word width (`loadWide` = 1) uses bit 15 as the sign bit.
- R9: Kind codes 5, 6 and 7 are unused and make OF read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| loadEn | input | 1 | Capture strobe for a new operation record |
| loadKind | input | 3 | Operation kind code (0 eager, 1 inc, 2 dec, 3 sub, 4 shift) |
| loadSrc | input | 16 | Source operand |
| loadDst | input | 16 | Destination operand (value before the operation) |
| loadRes | input | 16 | Result, or the flag word for the eager kind |
| loadWide | input | 1 | 1 for word width, 0 for byte width |
| ofOut | output | 1 | Overflow flag computed from the stored record |

## Verification
Each kind is loaded with values on both sides of its rule. For increment and decrement these are the exact boundary result and its neighbours. For subtract they are sign combinations where exactly one of the two conditions holds. For shift they are destination/result pairs with equal and with different sign bits. The same records are applied at both widths, and the byte cases also set the upper byte, so that a design using the wrong sign bit or a full-width compare gives a different flag. Eager records with bit 11 set and clear, unused kind codes with bit 11 set, and a flag read taken just before the capture edge check the fixed bit position, the default decode and the one-cycle latency.

// File: rtl/ovf_pkg.sv
package ovf_pkg;

  typedef enum logic [2:0] {
    KIND_EAGER = 3'd0,
    KIND_INC   = 3'd1,
    KIND_DEC   = 3'd2,
    KIND_SUB   = 3'd3,
    KIND_SHIFT = 3'd4
  } opKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic wide;
    logic selEager;
    logic selInc;
    logic selDec;
    logic selSub;
    logic selShift;
  } ovfStrobe_t;

endpackage

// File: rtl/ovf_ctrl.sv
module ovf_ctrl
  import ovf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadEn,
  input  logic [2:0] loadKind,
  input  logic       loadWide,
  output ovfStrobe_t strobes
);

  logic [2:0] kindQ;
  logic       wideQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindQ <= KIND_EAGER;
      wideQ <= 1'b1;
    end else if (loadEn) begin
      kindQ <= loadKind;
      wideQ <= loadWide;
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.capture  = loadEn;
    strobes.wide     = wideQ;
    case (kindQ)
      KIND_EAGER: strobes.selEager = 1'b1;
      KIND_INC:   strobes.selInc   = 1'b1;
      KIND_DEC:   strobes.selDec   = 1'b1;
      KIND_SUB:   strobes.selSub   = 1'b1;
      KIND_SHIFT: strobes.selShift = 1'b1;
      default:    ;  // unused codes select nothing (R9)
    endcase
  end

  // R9: at most one rule is selected at any time
  a_r9_one_rule: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.selEager, strobes.selInc, strobes.selDec,
              strobes.selSub, strobes.selShift}));

endmodule

// File: rtl/ovf_dpath.sv
module ovf_dpath
  import ovf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int OF_POS = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  ovfStrobe_t        strobes,
  input  logic [DATA_W-1:0] loadSrc,
  input  logic [DATA_W-1:0] loadDst,
  input  logic [DATA_W-1:0] loadRes,
  output logic              ofOut
);

  localparam logic [DATA_W-1:0] LOW_MASK  = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
  localparam logic [DATA_W-1:0] WORD_SIGN = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] BYTE_SIGN = {{(DATA_W-BYTE_W){1'b0}}, 1'b1, {(BYTE_W-1){1'b0}}};

  logic [DATA_W-1:0] srcQ, dstQ, resQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcQ <= '0;
      dstQ <= '0;
      resQ <= '0;
    end else if (strobes.capture) begin
      srcQ <= loadSrc;
      dstQ <= loadDst;
      resQ <= loadRes;
    end
  end

  // width-dependent views
  logic [DATA_W-1:0] resView, signMask;
  logic              srcSign, dstSign, resSign;

  always_comb begin
    signMask = strobes.wide ? WORD_SIGN : BYTE_SIGN;
    resView  = strobes.wide ? resQ : (resQ & LOW_MASK);
    srcSign  = strobes.wide ? srcQ[DATA_W-1] : srcQ[BYTE_W-1];
    dstSign  = strobes.wide ? dstQ[DATA_W-1] : dstQ[BYTE_W-1];
    resSign  = strobes.wide ? resQ[DATA_W-1] : resQ[BYTE_W-1];
  end

  // per-kind candidate overflow bits
  logic ofEager, ofInc, ofDec, ofSub, ofShift;

  always_comb begin
    ofEager = resQ[OF_POS];
    ofInc   = (resView == signMask);
    ofDec   = (resView == (signMask - 1'b1));
    ofSub   = (srcSign ^ dstSign) & (dstSign ^ resSign);
    ofShift = dstSign ^ resSign;
  end

  assign ofOut = (strobes.selEager & ofEager) |
                 (strobes.selInc   & ofInc)   |
                 (strobes.selDec   & ofDec)   |
                 (strobes.selSub   & ofSub)   |
                 (strobes.selShift & ofShift);

  // R6: a word-wide shift record whose operand sign bits differ yields OF
  a_r6_shift_word: assert property (@(posedge clk) disable iff (!rstN)
    strobes.selShift && strobes.wide && (dstQ[DATA_W-1] != resQ[DATA_W-1]) |-> ofOut);

endmodule

// File: rtl/ovf_lazy_top.sv
module ovf_lazy_top
  import ovf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int OF_POS = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [2:0]        loadKind,
  input  logic [DATA_W-1:0] loadSrc,
  input  logic [DATA_W-1:0] loadDst,
  input  logic [DATA_W-1:0] loadRes,
  input  logic              loadWide,
  output logic              ofOut
);

  ovfStrobe_t strobes;

  ovf_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .loadEn   (loadEn),
    .loadKind (loadKind),
    .loadWide (loadWide),
    .strobes  (strobes)
  );

  ovf_dpath #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W),
    .OF_POS (OF_POS)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .loadSrc (loadSrc),
    .loadDst (loadDst),
    .loadRes (loadRes),
    .ofOut   (ofOut)
  );

  localparam logic [DATA_W-1:0] WORD_SIGN = {1'b1, {(DATA_W-1){1'b0}}};

  // R2: without a load the flag holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !loadEn |=> $stable(ofOut));

  // R3: word increment landing on the sign mask overflows
  a_r3_inc_word: assert property (@(posedge clk) disable iff (!rstN)
    loadEn && loadKind == KIND_INC && loadWide && loadRes == WORD_SIGN |=> ofOut);

  // R4: byte decrement landing on 0x7F overflows, upper byte ignored (R8)
  a_r4_dec_byte: assert property (@(posedge clk) disable iff (!rstN)
    loadEn && loadKind == KIND_DEC && !loadWide &&
    loadRes[BYTE_W-1:0] == {1'b0, {(BYTE_W-1){1'b1}}} |=> ofOut);

  // R7: eager kind copies the fixed flag-word bit
  a_r7_eager: assert property (@(posedge clk) disable iff (!rstN)
    loadEn && loadKind == KIND_EAGER |=> ofOut == $past(loadRes[OF_POS]));

  // R9: unused kind codes never report overflow
  a_r9_unused: assert property (@(posedge clk) disable iff (!rstN)
    loadEn && loadKind > KIND_SHIFT |=> !ofOut);

endmodule

// File: tb/ovf_lazy_top_tb_top.sv
module ovf_lazy_top_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadEn = 1'b0;
  logic [2:0]  loadKind = 3'd0;
  logic [15:0] loadSrc = '0, loadDst = '0, loadRes = '0;
  logic        loadWide = 1'b0;
  logic        ofOut;

  int vecCount = 0;
  int errCount = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ovf_lazy_top dut_i (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadKind(loadKind),
    .loadSrc(loadSrc), .loadDst(loadDst), .loadRes(loadRes),
    .loadWide(loadWide), .ofOut(ofOut)
  );

  task automatic check(input string req, input logic exp);
    vecCount++;
    if (ofOut !== exp) begin
      errCount++;
      $display("FAIL %s: ofOut=%b expected=%b", req, ofOut, exp);
    end
  endtask

  // drive at negedge, capture at next posedge, sample at following negedge
  task automatic loadRec(input logic [2:0] k, input logic w,
                         input logic [15:0] s, input logic [15:0] d, input logic [15:0] r);
    @(negedge clk);
    loadKind = k; loadWide = w; loadSrc = s; loadDst = d; loadRes = r; loadEn = 1'b1;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic tryRec(input string req, input logic [2:0] k, input logic w,
                        input logic [15:0] s, input logic [15:0] d, input logic [15:0] r,
                        input logic exp);
    loadRec(k, w, s, d, r);
    check(req, exp);
  endtask

  task automatic testReset();
    check("R1", 1'b0);
  endtask

  task automatic testInc();
    tryRec("R3", 3'd1, 1'b1, 16'h0001, 16'h7FFF, 16'h8000, 1'b1);
    tryRec("R3", 3'd1, 1'b1, 16'h0001, 16'h7FFE, 16'h7FFF, 1'b0);
    tryRec("R3", 3'd1, 1'b0, 16'h0001, 16'h007F, 16'h0080, 1'b1);
    tryRec("R3", 3'd1, 1'b0, 16'h0001, 16'h7FFF, 16'h8000, 1'b0);
    tryRec("R8", 3'd1, 1'b0, 16'h0001, 16'h017F, 16'h0180, 1'b1);
  endtask

  task automatic testDec();
    tryRec("R4", 3'd2, 1'b1, 16'h0001, 16'h8000, 16'h7FFF, 1'b1);
    tryRec("R4", 3'd2, 1'b1, 16'h0001, 16'h0080, 16'h007F, 1'b0);
    tryRec("R4", 3'd2, 1'b0, 16'h0001, 16'h0080, 16'h007F, 1'b1);
    tryRec("R8", 3'd2, 1'b0, 16'h0001, 16'hFF80, 16'hFF7F, 1'b1);
    tryRec("R4", 3'd2, 1'b0, 16'h0001, 16'h0081, 16'h0080, 1'b0);
  endtask

  task automatic testSub();
    tryRec("R5", 3'd3, 1'b1, 16'hFFFF, 16'h7FFF, 16'h8000, 1'b1);
    tryRec("R5", 3'd3, 1'b1, 16'h0001, 16'h8000, 16'h7FFF, 1'b1);
    tryRec("R5", 3'd3, 1'b1, 16'h0003, 16'h0005, 16'h0002, 1'b0);
    tryRec("R5", 3'd3, 1'b1, 16'hFFFF, 16'h0001, 16'h0002, 1'b0);
    tryRec("R5", 3'd3, 1'b0, 16'h0001, 16'h0080, 16'h007F, 1'b1);
    tryRec("R8", 3'd3, 1'b0, 16'h8001, 16'h0080, 16'h807F, 1'b1);
    tryRec("R8", 3'd3, 1'b0, 16'h0001, 16'h8000, 16'h7FFF, 1'b0);
  endtask

  task automatic testShift();
    tryRec("R6", 3'd4, 1'b1, 16'h0001, 16'h4000, 16'h8000, 1'b1);
    tryRec("R6", 3'd4, 1'b1, 16'h0001, 16'hC000, 16'h8000, 1'b0);
    tryRec("R6", 3'd4, 1'b0, 16'h0001, 16'h0040, 16'h0080, 1'b1);
    tryRec("R8", 3'd4, 1'b0, 16'h0001, 16'h4040, 16'h8000, 1'b0);
  endtask

  task automatic testEager();
    tryRec("R7", 3'd0, 1'b1, 16'h0000, 16'h0000, 16'h0800, 1'b1);
    tryRec("R7", 3'd0, 1'b0, 16'h0000, 16'h0000, 16'h0800, 1'b1);
    tryRec("R7", 3'd0, 1'b1, 16'h0000, 16'h0000, 16'hF7FF, 1'b0);
  endtask

  task automatic testUnused();
    tryRec("R9", 3'd5, 1'b1, 16'h0001, 16'h4000, 16'h8800, 1'b0);
    tryRec("R9", 3'd7, 1'b0, 16'h0001, 16'h0040, 16'h0880, 1'b0);
  endtask

  task automatic testTiming();
    loadRec(3'd1, 1'b1, 16'h0001, 16'h7FFF, 16'h8000);
    check("R2", 1'b1);
    // new record presented, flag must not move before the capture edge
    @(negedge clk);
    loadKind = 3'd1; loadWide = 1'b1; loadRes = 16'h1234; loadEn = 1'b1;
    #1;
    check("R2", 1'b1);
    @(negedge clk);
    loadEn = 1'b0;
    check("R2", 1'b0);
    // inputs changing with loadEn low have no effect
    loadRes = 16'h8000;
    repeat (3) @(negedge clk);
    check("R2", 1'b0);
  endtask

  initial begin
    fork
      begin
        repeat (2) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        testReset();
        testInc();
        testDec();
        testSub();
        testShift();
        testEager();
        testUnused();
        testTiming();
        done = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          vecCount++;
          errCount++;
          $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        end
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

endmodule